// File: doc/BRIEF.md
# Equalized Carrier Output Multiplexer

This block sits after the equalizer of an OFDM demodulator. Each active carrier of a symbol arrives as one parallel word: the corrected I and Q values, a 4-bit confidence factor, an 8-bit squared channel magnitude and three marker bits that say whether the carrier is a continual pilot, a scattered pilot or a signalling (TPS) carrier. The block serialises every carrier onto a narrow output port over two clock cycles, I first and Q second. A phase strobe tells the receiver which half of the pair is on the bus. The confidence factor travels beside I, and the upper half of the magnitude travels beside Q. A second side bus holds the lower half of the magnitude for the whole pair.

Alongside the data the block labels each carrier. It marks the first carrier of a symbol, marks regular data carriers and signalling carriers, and flags every carrier of the first symbol of a frame and of a superframe. It keeps its own carrier, symbol and frame counters to do this. An external sync pulse forces those counters to the start of a superframe. A mode input selects the short (2K, 1705 carriers) or long (8K, 6817 carriers) symbol length. With the default parameters a frame holds 68 symbols and a superframe holds 4 frames.

Top module: `carrier_out_mux`

## Requirements
- R1: A carrier accepted at a clock edge (carValid high while carRdy is high) puts its I value on dOut in the next cycle and its Q value in the cycle after. Carriers leave in the order they were accepted.
- R2: phaseOut is 1 during the I cycle of a carrier. It is 0 during the Q cycle and while no carrier is being output.
- R3: sideOut carries the confidence factor during the I cycle and magnitude bits [7:4] during the Q cycle. magLo carries magnitude bits [3:0] during both cycles.
- R4: startOut is high in both cycles of carrier index 0 of every symbol. A symbol holds CAR_2K carriers when mode8k is 0 and CAR_8K carriers when mode8k is 1.
- R5: On carrier index 0, dataValidOut and tpsValidOut are both low, whatever marker bits come with that carrier.
- R6: dataValidOut is high in both cycles of a carrier that has none of isCp, isSp or isTps set. tpsValidOut is high on a carrier with isTps set and neither pilot bit set. Both outputs are low in every other case, including idle cycles.
- R7: frameOut is high in both cycles of every carrier of symbol 0 of a frame. A frame holds SYM_PER_FRAME symbols.
- R8: In long mode superOut equals frameOut. In short mode superOut is high only on symbol 0 of frame 0, where a superframe holds FRAMES_PER_SUPER frames.
- R9: A frameSync pulse makes the carrier accepted in the same cycle, or else the next accepted carrier, carrier 0 of symbol 0 of frame 0.
- R10: carRdy is low during an I cycle. A carValid presented then is ignored: it produces no output and does not advance the counters.
- R11: After reset phaseOut, startOut, dataValidOut, tpsValidOut, frameOut and superOut are low, carRdy is high, and the next carrier is carrier 0 of symbol 0 of frame 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mode8k | input | 1 | 1 selects the long symbol length, 0 the short |
| frameSync | input | 1 | Forces the counters to the start of a superframe |
| carValid | input | 1 | Carrier word present |
| carI | input | DATA_W | Equalized in-phase value |
| carQ | input | DATA_W | Equalized quadrature value |
| carConf | input | SIDE_W | Confidence factor |
| carMag | input | 2*SIDE_W | Squared channel magnitude |
| isCp | input | 1 | Carrier is a continual pilot |
| isSp | input | 1 | Carrier is a scattered pilot |
| isTps | input | 1 | Carrier is a signalling carrier |
| carRdy | output | 1 | A carrier can be accepted this cycle |
| dOut | output | DATA_W | Multiplexed I/Q output |
| sideOut | output | SIDE_W | Confidence (I cycle) or magnitude upper half (Q cycle) |
| magLo | output | SIDE_W | Magnitude lower half |
| phaseOut | output | 1 | 1 in the I cycle |
| startOut | output | 1 | First carrier of a symbol |
| dataValidOut | output | 1 | Regular data carrier |
| tpsValidOut | output | 1 | Signalling carrier |
| frameOut | output | 1 | Carrier belongs to the first symbol of a frame |
| superOut | output | 1 | Carrier belongs to the first symbol of a superframe |

## Verification
The hardest states to reach from the ports are the superframe boundaries. At the default lengths they lie hundreds of thousands of cycles apart, and the difference between the 2K and 8K marker rules only shows on the first symbol of frames 1 to 3. The bench therefore instantiates the block with short carrier, symbol and frame counts. It then streams random carriers with random gaps past several frame wraps in both modes, and uses frameSync, both alone and together with a mid-symbol carrier, to realign. Directed cases drive a carrier word during an I cycle and present an unmarked carrier at index 0.

// File: rtl/carrier_out_mux_pkg.sv
package carrier_out_mux_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_I    = 2'd1,
    ST_Q    = 2'd2
  } out_state_t;

  typedef struct packed {
    logic capture;
    logic showQ;
  } mux_strobe_t;

endpackage

// File: rtl/carrier_out_ctrl.sv
module carrier_out_ctrl
  import carrier_out_mux_pkg::*;
#(
  parameter int CAR_2K           = 1705,
  parameter int CAR_8K           = 6817,
  parameter int SYM_PER_FRAME    = 68,
  parameter int FRAMES_PER_SUPER = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        mode8k,
  input  logic        frameSync,
  input  logic        carValid,
  input  logic        isCp,
  input  logic        isSp,
  input  logic        isTps,
  output logic        carRdy,
  output mux_strobe_t strb,
  output logic        phaseOut,
  output logic        startOut,
  output logic        dataValidOut,
  output logic        tpsValidOut,
  output logic        frameOut,
  output logic        superOut
);

  localparam int CAR_MAX = (CAR_8K > CAR_2K) ? CAR_8K : CAR_2K;
  localparam int CAR_W   = $clog2(CAR_MAX);
  localparam int SYM_W   = $clog2(SYM_PER_FRAME);
  localparam int FRM_W   = $clog2(FRAMES_PER_SUPER);
  localparam logic [CAR_W-1:0] LAST_2K  = CAR_W'(CAR_2K - 1);
  localparam logic [CAR_W-1:0] LAST_8K  = CAR_W'(CAR_8K - 1);
  localparam logic [SYM_W-1:0] LAST_SYM = SYM_W'(SYM_PER_FRAME - 1);
  localparam logic [FRM_W-1:0] LAST_FRM = FRM_W'(FRAMES_PER_SUPER - 1);

  out_state_t state;
  logic [CAR_W-1:0] carCnt, curCar, lastCar;
  logic [SYM_W-1:0] symCnt, curSym;
  logic [FRM_W-1:0] frmCnt, curFrm;
  logic capture, isFirst, noMark;
  logic fStart, fData, fTps, fFrame, fSuper;

  assign carRdy  = (state != ST_I);
  assign capture = carValid && carRdy;
  assign strb.capture = capture;
  assign strb.showQ   = (state == ST_Q);

  // Label of the carrier taken this cycle; a sync pulse wins over the counters.
  assign curCar  = frameSync ? '0 : carCnt;
  assign curSym  = frameSync ? '0 : symCnt;
  assign curFrm  = frameSync ? '0 : frmCnt;
  assign lastCar = mode8k ? LAST_8K : LAST_2K;
  assign isFirst = (curCar == '0);
  assign noMark  = !isCp && !isSp && !isTps;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: if (capture) state <= ST_I;
        ST_I:    state <= ST_Q;
        ST_Q:    state <= capture ? ST_I : ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      carCnt <= '0;
      symCnt <= '0;
      frmCnt <= '0;
    end else if (capture) begin
      if (curCar >= lastCar) begin
        carCnt <= '0;
        if (curSym == LAST_SYM) begin
          symCnt <= '0;
          frmCnt <= (curFrm == LAST_FRM) ? '0 : curFrm + 1'b1;
        end else begin
          symCnt <= curSym + 1'b1;
          frmCnt <= curFrm;
        end
      end else begin
        carCnt <= curCar + 1'b1;
        symCnt <= curSym;
        frmCnt <= curFrm;
      end
    end else if (frameSync) begin
      carCnt <= '0;
      symCnt <= '0;
      frmCnt <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fStart <= 1'b0;
      fData  <= 1'b0;
      fTps   <= 1'b0;
      fFrame <= 1'b0;
      fSuper <= 1'b0;
    end else if (capture) begin
      fStart <= isFirst;
      fData  <= !isFirst && noMark;
      fTps   <= !isFirst && isTps && !isCp && !isSp;
      fFrame <= (curSym == '0);
      fSuper <= (curSym == '0) && (mode8k || (curFrm == '0));
    end
  end

  logic busy;
  assign busy         = (state != ST_IDLE);
  assign phaseOut     = (state == ST_I);
  assign startOut     = busy && fStart;
  assign dataValidOut = busy && fData;
  assign tpsValidOut  = busy && fTps;
  assign frameOut     = busy && fFrame;
  assign superOut     = busy && fSuper;

  assert_q_follows_i_R2: assert property (@(posedge clk) disable iff (!rstN)
    phaseOut |=> !phaseOut);
  assert_i_after_take_R1: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> phaseOut);
  assert_start_two_cycles_R4: assert property (@(posedge clk) disable iff (!rstN)
    (startOut && phaseOut) |=> (startOut && !phaseOut));
  assert_start_not_valid_R5: assert property (@(posedge clk) disable iff (!rstN)
    startOut |-> (!dataValidOut && !tpsValidOut));
  assert_valid_exclusive_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(dataValidOut && tpsValidOut));
  assert_super_in_frame_R8: assert property (@(posedge clk) disable iff (!rstN)
    superOut |-> frameOut);
  assert_no_take_in_i_R10: assert property (@(posedge clk) disable iff (!rstN)
    phaseOut |-> !strb.capture);

endmodule

// File: rtl/carrier_out_dp.sv
module carrier_out_dp
  import carrier_out_mux_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SIDE_W = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  mux_strobe_t           strb,
  input  logic [DATA_W-1:0]     carI,
  input  logic [DATA_W-1:0]     carQ,
  input  logic [SIDE_W-1:0]     carConf,
  input  logic [2*SIDE_W-1:0]   carMag,
  output logic [DATA_W-1:0]     dOut,
  output logic [SIDE_W-1:0]     sideOut,
  output logic [SIDE_W-1:0]     magLo
);

  localparam int MAG_W = 2 * SIDE_W;

  logic [DATA_W-1:0] iReg, qReg;
  logic [SIDE_W-1:0] confReg;
  logic [MAG_W-1:0]  magReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      iReg    <= '0;
      qReg    <= '0;
      confReg <= '0;
      magReg  <= '0;
    end else if (strb.capture) begin
      iReg    <= carI;
      qReg    <= carQ;
      confReg <= carConf;
      magReg  <= carMag;
    end
  end

  assign dOut    = strb.showQ ? qReg : iReg;
  assign sideOut = strb.showQ ? magReg[MAG_W-1:SIDE_W] : confReg;
  assign magLo   = magReg[SIDE_W-1:0];

  assert_lsb_held_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.showQ |-> $stable(magLo));
  assert_take_then_i_R1: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> !strb.showQ);

endmodule

// File: rtl/carrier_out_mux.sv
module carrier_out_mux
  import carrier_out_mux_pkg::*;
#(
  parameter int DATA_W           = 8,
  parameter int SIDE_W           = 4,
  parameter int CAR_2K           = 1705,
  parameter int CAR_8K           = 6817,
  parameter int SYM_PER_FRAME    = 68,
  parameter int FRAMES_PER_SUPER = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                mode8k,
  input  logic                frameSync,
  input  logic                carValid,
  input  logic [DATA_W-1:0]   carI,
  input  logic [DATA_W-1:0]   carQ,
  input  logic [SIDE_W-1:0]   carConf,
  input  logic [2*SIDE_W-1:0] carMag,
  input  logic                isCp,
  input  logic                isSp,
  input  logic                isTps,
  output logic                carRdy,
  output logic [DATA_W-1:0]   dOut,
  output logic [SIDE_W-1:0]   sideOut,
  output logic [SIDE_W-1:0]   magLo,
  output logic                phaseOut,
  output logic                startOut,
  output logic                dataValidOut,
  output logic                tpsValidOut,
  output logic                frameOut,
  output logic                superOut
);

  mux_strobe_t strb;

  carrier_out_ctrl #(
    .CAR_2K(CAR_2K), .CAR_8K(CAR_8K),
    .SYM_PER_FRAME(SYM_PER_FRAME), .FRAMES_PER_SUPER(FRAMES_PER_SUPER)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .mode8k(mode8k), .frameSync(frameSync),
    .carValid(carValid), .isCp(isCp), .isSp(isSp), .isTps(isTps),
    .carRdy(carRdy), .strb(strb), .phaseOut(phaseOut), .startOut(startOut),
    .dataValidOut(dataValidOut), .tpsValidOut(tpsValidOut),
    .frameOut(frameOut), .superOut(superOut)
  );

  carrier_out_dp #(.DATA_W(DATA_W), .SIDE_W(SIDE_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .carI(carI), .carQ(carQ),
    .carConf(carConf), .carMag(carMag), .dOut(dOut), .sideOut(sideOut),
    .magLo(magLo)
  );

endmodule

// File: tb/carrier_out_mux_bench.sv
`timescale 1ns/1ps
module carrier_out_mux_bench;

  localparam int C2K = 5;
  localparam int C8K = 9;
  localparam int SPF = 3;
  localparam int FPS = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mode8k = 1'b0, frameSync = 1'b0, carValid = 1'b0;
  logic [7:0] carI = '0, carQ = '0, carMag = '0;
  logic [3:0] carConf = '0;
  logic isCp = 1'b0, isSp = 1'b0, isTps = 1'b0;
  logic carRdy, phaseOut, startOut, dataValidOut, tpsValidOut, frameOut, superOut;
  logic [7:0] dOut;
  logic [3:0] sideOut, magLo;

  int checks = 0;
  int errors = 0;
  int bCar = 0, bSym = 0, bFrm = 0;

  always #10 clk = ~clk;

  carrier_out_mux #(.CAR_2K(C2K), .CAR_8K(C8K), .SYM_PER_FRAME(SPF),
                    .FRAMES_PER_SUPER(FPS)) u_carrier_out_mux (
    .clk(clk), .rstN(rstN), .mode8k(mode8k), .frameSync(frameSync),
    .carValid(carValid), .carI(carI), .carQ(carQ), .carConf(carConf),
    .carMag(carMag), .isCp(isCp), .isSp(isSp), .isTps(isTps),
    .carRdy(carRdy), .dOut(dOut), .sideOut(sideOut), .magLo(magLo),
    .phaseOut(phaseOut), .startOut(startOut), .dataValidOut(dataValidOut),
    .tpsValidOut(tpsValidOut), .frameOut(frameOut), .superOut(superOut)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int lastCar(input bit m);
    return m ? C8K - 1 : C2K - 1;
  endfunction

  function automatic bit expSuper(input int sym, input int frm, input bit m);
    return (sym == 0) && (m || frm == 0);
  endfunction

  task automatic advance();
    if (bCar >= lastCar(mode8k)) begin
      bCar = 0;
      if (bSym == SPF - 1) begin
        bSym = 0;
        bFrm = (bFrm == FPS - 1) ? 0 : bFrm + 1;
      end else bSym++;
    end else bCar++;
  endtask

  // Called at a negedge; returns at a negedge.
  task automatic sendCar(input bit withSync, input bit poke, input bit forceBare);
    logic [7:0] vI, vQ, vM;
    logic [3:0] vC;
    bit cp, sp, tps, first, eDv, eTps, eFr, eSu;
    int f;
    while (!carRdy) @(negedge clk);
    vI = 8'($urandom); vQ = 8'($urandom); vM = 8'($urandom); vC = 4'($urandom);
    f = int'($urandom % 6);
    cp = (f == 0) || (f == 3); sp = (f == 1); tps = (f == 2) || (f == 3);
    if (forceBare) begin cp = 0; sp = 0; tps = 0; end
    carI = vI; carQ = vQ; carMag = vM; carConf = vC;
    isCp = cp; isSp = sp; isTps = tps; carValid = 1'b1; frameSync = withSync;
    if (withSync) begin bCar = 0; bSym = 0; bFrm = 0; end
    first = (bCar == 0);
    eDv  = !first && !cp && !sp && !tps;
    eTps = !first && tps && !cp && !sp;
    eFr  = (bSym == 0);
    eSu  = expSuper(bSym, bFrm, mode8k);
    advance();
    @(posedge clk); @(negedge clk);
    frameSync = 1'b0;
    if (poke) begin
      carI = ~vI; carQ = ~vQ; isCp = 0; isSp = 0; isTps = 0; carValid = 1'b1;
    end else carValid = 1'b0;
    // I cycle
    chk("R1 I data", dOut, vI);
    chk("R2 phase in I", phaseOut, 1);
    chk("R3 confidence", sideOut, vC);
    chk("R3 mag low in I", magLo, vM[3:0]);
    chk("R4 start in I", startOut, first);
    chk(first ? "R5 dv on first" : "R6 dv in I", dataValidOut, eDv);
    chk(first ? "R5 tps on first" : "R6 tps in I", tpsValidOut, eTps);
    chk("R7 frame in I", frameOut, eFr);
    chk("R8 super in I", superOut, eSu);
    chk("R10 ready low in I", carRdy, 0);
    @(posedge clk); @(negedge clk);
    carValid = 1'b0;
    // Q cycle
    chk("R1 Q data", dOut, vQ);
    chk("R2 phase in Q", phaseOut, 0);
    chk("R3 mag high", sideOut, vM[7:4]);
    chk("R3 mag low in Q", magLo, vM[3:0]);
    chk("R4 start in Q", startOut, first);
    chk("R6 dv in Q", dataValidOut, eDv);
    chk("R6 tps in Q", tpsValidOut, eTps);
    chk("R7 frame in Q", frameOut, eFr);
    chk("R8 super in Q", superOut, eSu);
    if (withSync) chk("R9 sync gives first carrier", startOut, 1);
    if (poke) begin
      @(posedge clk); @(negedge clk);
      chk("R10 poke gives no I", phaseOut, 0);
      chk("R10 poke gives no dv", dataValidOut, 0);
      chk("R10 poke gives no start", startOut, 0);
    end
  endtask

  task automatic syncAlone();
    frameSync = 1'b1; carValid = 1'b0;
    @(posedge clk); @(negedge clk);
    frameSync = 1'b0;
    bCar = 0; bSym = 0; bFrm = 0;
  endtask

  task automatic gap();
    repeat (int'($urandom % 3)) @(negedge clk);
  endtask

  initial begin
    int seedDummy;
    seedDummy = int'($urandom(32'h5eed));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R11 reset phase", phaseOut, 0);
    chk("R11 reset start", startOut, 0);
    chk("R11 reset dv", dataValidOut, 0);
    chk("R11 reset tps", tpsValidOut, 0);
    chk("R11 reset frame", frameOut, 0);
    chk("R11 reset super", superOut, 0);
    chk("R11 reset ready", carRdy, 1);
    rstN = 1'b1;
    @(negedge clk);
    // R11: first carrier after reset is carrier 0 of a superframe, no marker bits
    sendCar(0, 0, 1);
    chk("R11 first after reset super", int'(bCar), 1);
    mode8k = 1'b0;
    syncAlone();
    sendCar(0, 0, 1);  // R5: unmarked carrier at index 0
    for (int i = 0; i < 75; i++) begin
      sendCar(0, (i == 17) || (i == 40), 0);
      gap();
    end
    sendCar(1, 0, 0);  // R9: sync together with a carrier mid-stream
    for (int i = 0; i < 12; i++) begin
      sendCar(0, 0, 0);
    end
    mode8k = 1'b1;
    sendCar(1, 0, 0);
    for (int i = 0; i < 80; i++) begin
      sendCar(0, (i == 30), 0);
      gap();
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule